// File: doc/BRIEF.md
# Overlapped-Command Serial Converter Sequencer

This block is the host-side sequencer for a serial touch-screen converter with 12-bit and 8-bit results. It produces the converter's serial clock from the system clock, holds chip select low, shifts out 8-bit control words, and captures the result bits that come back. It keeps the stream dense: the control word for the next conversion goes out while the tail of the current result is still arriving. When commands are always available, a new conversion starts every 16 serial clocks, or every 15 if the short frame is selected.

Commands enter through a valid/ready handshake that carries a channel, a resolution mode, a reference-mode bit and a two-bit power field. Each finished conversion appears on a one-cycle result strobe. The strobe carries the data together with the channel and mode of the command that produced it. The frame length and the clock divisor are run-time inputs. The frame length is latched when a command is accepted, so it only takes effect at a frame boundary.

Top module: `adc_stream_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock and data-in line are low, no result strobe is asserted and the command ready line is high.
- R2: Each accepted command is sent MSB first as the byte {1, chan[2:0], mode8, dfr, pd[1:0]}. Bit 7 is a start bit that is always 1. Bits 6..4 are the channel, bit 3 selects 8-bit resolution, bit 2 is the reference-mode bit and bits 1..0 are the power field.
- R3: Every serial clock phase, high or low, lasts `div_i` system cycles (0 counts as 1). Data-in changes only while the serial clock is low. The returned bits are taken at rising serial clock edges.
- R4: With `frame15_i` low and commands always available, the start bits of consecutive conversions are 16 rising serial clock edges apart.
- R5: With `frame15_i` high and commands always available, consecutive start bits are 15 rising edges apart.
- R6: In 12-bit mode, the result is the 12 bits on the converter's data-out line at rising edges 10 through 21 of a conversion, where the start bit's edge is edge 1. The first bit taken is the MSB.
- R7: In 8-bit mode, the result is the 8 bits at rising edges 10 through 17, MSB first, and it is presented zero-extended to 12 bits.
- R8: Each result is flagged by a strobe that lasts exactly one system cycle. It carries the channel and mode of its command, and results come out in command order.
- R9: If the converter's busy line is low at rising edge 9 of a conversion, that conversion produces no result.
- R10: Chip select stays low for a whole run of back-to-back commands. It rises only after the last pending result has been delivered and no command was taken at the frame boundary. The serial clock is low whenever chip select is high.
- R11: The frame length used for the gap after a conversion is the value of `frame15_i` when that conversion's command was accepted. Changes in the middle of a frame have no effect until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | System cycles per serial clock phase |
| frame15_i | input | 1 | 1 selects 15-clock frames, 0 selects 16-clock frames |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command taken on this cycle if valid |
| cmd_chan_i | input | 3 | Channel address |
| cmd_mode8_i | input | 1 | 1 selects 8-bit resolution |
| cmd_dfr_i | input | 1 | Reference-mode bit |
| cmd_pd_i | input | 2 | Power field |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_dclk_o | output | 1 | Serial clock to the converter |
| adc_din_o | output | 1 | Serial data to the converter |
| adc_busy_i | input | 1 | Busy line from the converter |
| adc_dout_i | input | 1 | Serial data from the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Result, zero-extended in 8-bit mode |
| res_chan_o | output | 3 | Channel of the result's command |
| res_mode8_o | output | 1 | Mode of the result's command |

## Verification
The bench builds the block with DIV_W set to 4, so the widest divisor the input can express, 15, is used in a run alongside divisors of 1, 2 and 3. A divisor of 1 gives single-cycle serial clock phases, where the rise and fall events of the divider fall on consecutive system cycles. The bench also mixes 15- and 16-clock frames, flips the frame select in the middle of frames, suppresses busy for one conversion, and issues a lone command. Together these reach the overlap windows, the stop-after-last-result path and the frame-boundary latch.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int CTRL_BITS  = 8;
    localparam int RES_BITS   = 12;
    localparam int RES8_BITS  = 8;
    localparam int POS_W      = 5;
    localparam int LEFT_W     = 4;
    // rise index (0-based) at which busy is examined; result bits follow
    localparam int BUSY_POS   = 8;
    localparam int FRAME_LONG = 16;
    localparam int FRAME_SHORT = 15;

    typedef struct packed {
        logic [2:0] chan;
        logic       mode8;
        logic       dfr;
        logic [1:0] pd;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } seq_st_t;

    function automatic logic [CTRL_BITS-1:0] ctrl_word(cmd_t c);
        return {1'b1, c.chan, c.mode8, c.dfr, c.pd};
    endfunction

    function automatic logic [POS_W-1:0] frame_last(logic short_frame);
        return short_frame ? POS_W'(FRAME_SHORT - 1) : POS_W'(FRAME_LONG - 1);
    endfunction

endpackage

// File: rtl/adcseq_clkgen.sv
module adcseq_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             dclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             hit;

    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign hit  = run && (cnt == lim);
    assign rise = hit && !dclk;
    assign fall = hit && dclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            dclk <= 1'b0;
        end else if (hit) begin
            cnt  <= '0;
            dclk <= ~dclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       fall,
    input  logic       dclk,
    input  logic       cmd_valid,
    input  cmd_t       cmd,
    input  logic       frame15,
    input  logic       adc_busy,
    input  logic       cap_done_after,
    output logic       run,
    output logic       cs_n,
    output logic       din,
    output logic       cmd_ready,
    output logic       arm,
    output logic [2:0] arm_chan,
    output logic       arm_mode8
);
    seq_st_t              state;
    logic [POS_W-1:0]     pos;
    logic [POS_W-1:0]     len_last;
    cmd_t                 cur;
    logic                 has_cmd;
    logic [CTRL_BITS-1:0] cbyte;
    logic                 frame_end;
    logic                 accept;
    logic                 next_bit;

    assign cbyte     = ctrl_word(cur);
    assign frame_end = (state == ST_RUN) && rise && (pos == len_last);
    assign cmd_ready = (state == ST_IDLE) || frame_end;
    assign accept    = cmd_valid && cmd_ready;
    assign run       = (state != ST_IDLE);
    assign cs_n      = (state == ST_IDLE);
    assign arm       = (state == ST_RUN) && rise && has_cmd &&
                       (pos == POS_W'(BUSY_POS)) && adc_busy;
    assign arm_chan  = cur.chan;
    assign arm_mode8 = cur.mode8;
    // pos already points at the next rise when the fall arrives
    assign next_bit  = has_cmd && (pos < POS_W'(CTRL_BITS)) &&
                       cbyte[3'(3'd7 - pos[2:0])];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pos      <= '0;
            len_last <= frame_last(1'b0);
            cur      <= '0;
            has_cmd  <= 1'b0;
            din      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_RUN;
                        cur      <= cmd;
                        has_cmd  <= 1'b1;
                        len_last <= frame_last(frame15);
                        pos      <= '0;
                        din      <= 1'b1;
                    end else begin
                        din      <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (rise) begin
                        if (frame_end) begin
                            pos <= '0;
                            if (accept) begin
                                cur      <= cmd;
                                has_cmd  <= 1'b1;
                                len_last <= frame_last(frame15);
                            end else begin
                                has_cmd  <= 1'b0;
                            end
                        end else begin
                            pos <= pos + POS_W'(1);
                        end
                        if (!has_cmd && cap_done_after)
                            state <= ST_STOP;
                    end
                    if (fall)
                        din <= next_bit;
                end
                ST_STOP: begin
                    if (fall) begin
                        state <= ST_IDLE;
                        din   <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: data-in only moves while the serial clock sits low
    p_din_low_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(din) |-> !dclk);

    // R10: no serial clock activity with chip select released
    p_cs_clk_idle_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !dclk);

    // R4: frame position never passes the latched frame length
    p_pos_bound_r4: assert property (@(posedge clk) disable iff (rst)
        pos <= len_last);
endmodule

// File: rtl/adcseq_capture.sv
module adcseq_capture
    import adcseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                arm,
    input  logic [2:0]          arm_chan,
    input  logic                arm_mode8,
    input  logic                adc_dout,
    output logic                cap_done_after,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [2:0]          res_chan,
    output logic                res_mode8
);
    logic [LEFT_W-1:0]   left;
    logic [RES_BITS-2:0] sh;
    logic [2:0]          ctx_chan;
    logic                ctx_mode8;

    assign cap_done_after = (left <= LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left      <= '0;
            sh        <= '0;
            ctx_chan  <= '0;
            ctx_mode8 <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_chan  <= '0;
            res_mode8 <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (rise) begin
                if (left != '0) begin
                    sh   <= {sh[RES_BITS-3:0], adc_dout};
                    left <= left - LEFT_W'(1);
                    if (left == LEFT_W'(1)) begin
                        res_valid <= 1'b1;
                        res_chan  <= ctx_chan;
                        res_mode8 <= ctx_mode8;
                        res_data  <= ctx_mode8 ?
                            {{(RES_BITS-RES8_BITS){1'b0}}, sh[RES8_BITS-2:0], adc_dout} :
                            {sh, adc_dout};
                    end
                end
                if (arm) begin
                    left      <= arm_mode8 ? LEFT_W'(RES8_BITS) : LEFT_W'(RES_BITS);
                    ctx_chan  <= arm_chan;
                    ctx_mode8 <= arm_mode8;
                end
            end
        end
    end

    // R6: a new capture never starts over one still in flight
    p_arm_free_r6: assert property (@(posedge clk) disable iff (rst)
        arm |-> (left == '0));

    // R8: the result strobe lasts a single cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R7: short results carry zeros in the upper nibble
    p_zero_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_mode8) |-> (res_data[RES_BITS-1:RES8_BITS] == '0));
endmodule

// File: rtl/adc_stream_seq.sv
module adc_stream_seq
    import adcseq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             frame15_i,
    input  logic             cmd_valid_i,
    output logic             cmd_ready_o,
    input  logic [2:0]       cmd_chan_i,
    input  logic             cmd_mode8_i,
    input  logic             cmd_dfr_i,
    input  logic [1:0]       cmd_pd_i,
    output logic             adc_cs_n_o,
    output logic             adc_dclk_o,
    output logic             adc_din_o,
    input  logic             adc_busy_i,
    input  logic             adc_dout_i,
    output logic             res_valid_o,
    output logic [11:0]      res_data_o,
    output logic [2:0]       res_chan_o,
    output logic             res_mode8_o
);
    cmd_t       cmd;
    logic       run, rise, fall, dclk;
    logic       arm, arm_mode8, cap_done_after;
    logic [2:0] arm_chan;

    assign cmd = '{chan: cmd_chan_i, mode8: cmd_mode8_i, dfr: cmd_dfr_i, pd: cmd_pd_i};
    assign adc_dclk_o = dclk;

    adcseq_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .run(run), .div(div_i),
        .dclk(dclk), .rise(rise), .fall(fall)
    );

    adcseq_frame u_frame (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .dclk(dclk),
        .cmd_valid(cmd_valid_i), .cmd(cmd), .frame15(frame15_i),
        .adc_busy(adc_busy_i), .cap_done_after(cap_done_after),
        .run(run), .cs_n(adc_cs_n_o), .din(adc_din_o), .cmd_ready(cmd_ready_o),
        .arm(arm), .arm_chan(arm_chan), .arm_mode8(arm_mode8)
    );

    adcseq_capture u_cap (
        .clk(clk), .rst(rst), .rise(rise), .arm(arm),
        .arm_chan(arm_chan), .arm_mode8(arm_mode8), .adc_dout(adc_dout_i),
        .cap_done_after(cap_done_after), .res_valid(res_valid_o),
        .res_data(res_data_o), .res_chan(res_chan_o), .res_mode8(res_mode8_o)
    );
endmodule

// File: tb/adc_stream_seq_tb.sv
`timescale 1ns/1ps
module adc_stream_seq_tb;
    localparam int DIV_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DIV_W-1:0] div_i = 4'd2;
    logic frame15_i = 1'b0;
    logic cmd_valid_i = 1'b0;
    logic cmd_ready_o;
    logic [2:0] cmd_chan_i = '0;
    logic cmd_mode8_i = 1'b0, cmd_dfr_i = 1'b0;
    logic [1:0] cmd_pd_i = '0;
    logic adc_cs_n_o, adc_dclk_o, adc_din_o;
    logic adc_busy_i = 1'b0, adc_dout_i = 1'b0;
    logic res_valid_o;
    logic [11:0] res_data_o;
    logic [2:0] res_chan_o;
    logic res_mode8_o;

    always #2.5 clk = ~clk;

    adc_stream_seq #(.DIV_W(DIV_W)) u_dut (.*);

    int total = 0, bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] sample_val(int ch, int n);
        return 12'(ch * 419 + n * 91 + 801);
    endfunction

    // scoreboard queues
    logic [7:0]  exp_byte[$];
    int          exp_gap[$];
    logic [15:0] exp_res[$];   // {mode8, chan, data}

    int drv_seq = 0;
    int drop_seq = -1;

    task automatic send(input logic [2:0] ch, input logic m8, input logic dfr,
                        input logic [1:0] pd, input logic f15_after);
        logic [11:0] v;
        @(negedge clk);
        cmd_chan_i = ch; cmd_mode8_i = m8; cmd_dfr_i = dfr; cmd_pd_i = pd;
        cmd_valid_i = 1'b1;
        while (!cmd_ready_o) @(negedge clk);
        exp_byte.push_back({1'b1, ch, m8, dfr, pd});
        exp_gap.push_back(frame15_i ? 15 : 16);
        v = sample_val(ch, drv_seq);
        if (drv_seq != drop_seq)
            exp_res.push_back({m8, ch, m8 ? {4'b0, v[11:4]} : v});
        drv_seq++;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        frame15_i = f15_after;
    endtask

    // converter model
    int rises = 0, last_start = 0, conv_k = -1, rx_cnt = 0, dev_seq = 0;
    int cur_seq = 0, tx_left = 0, cs_rises = 0;
    bit have_start = 0;
    logic [7:0] rx_sh;
    logic [11:0] tx_sh;
    logic [2:0] dev_chan;
    logic dev_m8;

    always @(posedge adc_dclk_o) begin
        rises++;
        if (conv_k >= 0) conv_k++;
        if (rx_cnt == 0 && adc_din_o) begin
            rx_cnt = 1; rx_sh = 8'd1; conv_k = 1;
            if (have_start) begin
                // R4 / R5 / R11: start-to-start gap
                if (exp_gap.size() > 0) begin
                    int g;
                    g = exp_gap.pop_front();
                    check(rises - last_start == g, "R4/R5/R11 frame gap", rises - last_start, g);
                end else check(0, "R11 unexpected start", 0, 1);
            end
            have_start = 1; last_start = rises;
        end else if (rx_cnt > 0) begin
            rx_sh = {rx_sh[6:0], adc_din_o};
            rx_cnt++;
            if (rx_cnt == 8) begin
                rx_cnt = 0;
                if (exp_byte.size() > 0) begin
                    logic [7:0] eb;
                    eb = exp_byte.pop_front();
                    check(rx_sh == eb, "R2 control byte", rx_sh, eb);
                end else check(0, "R2 unexpected byte", rx_sh, 0);
                dev_chan = rx_sh[6:4]; dev_m8 = rx_sh[3];
                cur_seq = dev_seq; dev_seq++;
            end
        end
    end

    always @(negedge adc_dclk_o) begin
        if (conv_k == 8) adc_busy_i = (cur_seq != drop_seq);
        else if (conv_k == 9) begin
            logic [11:0] v;
            adc_busy_i = 1'b0;
            v = sample_val(int'(dev_chan), cur_seq);
            tx_sh = dev_m8 ? {v[11:4], 4'b0} : v;
            tx_left = dev_m8 ? 8 : 12;
            adc_dout_i = tx_sh[11];
        end else if (tx_left > 0) begin
            tx_sh = tx_sh << 1;
            tx_left--;
            adc_dout_i = (tx_left > 0) ? tx_sh[11] : 1'b0;
        end
    end

    always @(posedge adc_cs_n_o) begin
        cs_rises++;
        // R10: release only once every pending result is out
        check(exp_res.size() == 0, "R10 cs released with result pending", exp_res.size(), 0);
        if (exp_gap.size() > 0) void'(exp_gap.pop_front());
        have_start = 0; rises = 0; conv_k = -1; rx_cnt = 0;
    end

    // monitor: results, serial timing
    int half_cnt = 0, time_bad = 0, strobe_bad = 0;
    logic pd_clk = 0, pd_din = 0, pd_cs = 1, pd_val = 0;

    always @(negedge clk) begin
        if (!rst) begin
            half_cnt++;
            if (adc_dclk_o !== pd_clk) begin
                if (half_cnt != ((div_i == 0) ? 1 : int'(div_i))) time_bad++;
                half_cnt = 0;
            end
            if (pd_cs && !adc_cs_n_o) half_cnt = 0;
            if (adc_din_o !== pd_din && adc_dclk_o) time_bad++;
            if (adc_cs_n_o && adc_dclk_o) time_bad++;
            if (res_valid_o && pd_val) strobe_bad++;
            if (res_valid_o) begin
                if (exp_res.size() > 0) begin
                    logic [15:0] e;
                    e = exp_res.pop_front();
                    check({res_mode8_o, res_chan_o, res_data_o} == e,
                          "R6/R7/R8 result", {res_mode8_o, res_chan_o, res_data_o}, e);
                end else check(0, "R9 unexpected result", res_data_o, 0);
            end
        end
        pd_clk = adc_dclk_o; pd_din = adc_din_o; pd_cs = adc_cs_n_o; pd_val = res_valid_o;
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!adc_cs_n_o) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic end_phase(input string tag, input int cs_before);
        wait_idle();
        check(exp_res.size() == 0, {tag, " results delivered"}, exp_res.size(), 0);
        check(cs_rises - cs_before == 1, "R10 one cs burst", cs_rises - cs_before, 1);
        check(time_bad == 0, "R3 clock phase / din timing", time_bad, 0);
        check(strobe_bad == 0, "R8 single-cycle strobe", strobe_bad, 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(adc_cs_n_o == 1'b1, "R1 cs_n", adc_cs_n_o, 1);
        check(adc_dclk_o == 1'b0 && adc_din_o == 1'b0, "R1 dclk/din", {adc_dclk_o, adc_din_o}, 0);
        check(res_valid_o == 1'b0, "R1 res_valid", res_valid_o, 0);
        check(cmd_ready_o == 1'b1, "R1 cmd_ready", cmd_ready_o, 1);

        // R4, R6, R2: 16-clock frames, 12-bit
        div_i = 4'd2; frame15_i = 1'b0; c0 = cs_rises;
        send(3'd1, 0, 1, 2'b00, 0);
        send(3'd5, 0, 0, 2'b11, 0);
        send(3'd2, 0, 1, 2'b01, 0);
        send(3'd7, 0, 0, 2'b10, 0);
        end_phase("R6", c0);

        // R5, R7: 15-clock frames, mixed resolution, single-cycle phases
        div_i = 4'd1; frame15_i = 1'b1; c0 = cs_rises;
        send(3'd3, 1, 0, 2'b01, 1);
        send(3'd6, 0, 1, 2'b00, 1);
        send(3'd0, 1, 1, 2'b11, 1);
        send(3'd4, 1, 0, 2'b10, 1);
        end_phase("R7", c0);

        // R9: busy withheld for one conversion
        div_i = 4'd3; frame15_i = 1'b0; c0 = cs_rises;
        drop_seq = drv_seq + 1;
        send(3'd2, 0, 0, 2'b00, 0);
        send(3'd3, 0, 0, 2'b00, 0);
        send(3'd4, 1, 0, 2'b00, 0);
        end_phase("R9", c0);
        drop_seq = -1;

        // R10: lone command, widest divisor
        div_i = 4'd15; frame15_i = 1'b1; c0 = cs_rises;
        send(3'd6, 1, 1, 2'b01, 1);
        end_phase("R10", c0);

        // R11: frame select flipped mid-frame after each accept
        div_i = 4'd2; frame15_i = 1'b0; c0 = cs_rises;
        send(3'd1, 0, 0, 2'b00, 1);
        send(3'd2, 0, 0, 2'b00, 0);
        send(3'd3, 1, 0, 2'b00, 1);
        send(3'd5, 0, 0, 2'b00, 0);
        end_phase("R11", c0);

        check(exp_byte.size() == 0, "R2 all bytes seen", exp_byte.size(), 0);
        done = 1;
        report();
    end
endmodule